// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array with Power-Down Freeze

This block models a small programmable logic device. Eight outputs are each formed as the OR of eight AND product terms. Every term is taken over a shared literal bus that carries the true and complement forms of each logic input and of each output's feedback register. A configuration word selects which literals enter each term. It also decides, per output, whether the pin shows a clocked register or the combinational sum. A further product term per output acts as a combinational output enable.

One logic input is dual-use. With the power-down option cleared, it is an ordinary input. With the option set, it stops feeding the array, and a high level on it freezes the device. The freeze holds output data and output enables, leaves high-impedance pins in high impedance, and blocks register updates. The freeze starts at the clock edge that samples the pin high. Normal evaluation resumes at the first edge that samples it low, starting from the register state held through the freeze. Tri-state pins appear as a data and enable pair so that a held high-impedance state can be observed.

Top module: `sop_pld_core`

## Requirements
- R1: Literal positions: input j sits at literal 2*j (true) and 2*j+1 (complement). The register of output k sits at literal 2*(N_IN+k) (true) and 2*(N_IN+k)+1 (complement). A product term is the AND of its selected literals. A term with no literal selected contributes 0. Product-term mask bits for output o, term t, literal l sit at cfg_pt_i[(o*N_PT+t)*NLIT+l].
- R2: The node value of each output is the OR of its N_PT product terms, and the pin data is the complement of that node.
- R3: An output with cfg_reg_i[o]=1 shows the complement of its register on dout_o[o]. The register loads the sum at each rising clock edge that is not frozen. Every output's register, in either mode, drives the feedback literals.
- R4: An output with cfg_reg_i[o]=0 shows the complement of its current sum without a clock. Its enable is the AND of the literals selected by cfg_oe_i[o*NLIT +: NLIT]. An empty enable mask gives enable 1.
- R5: When not frozen, the enable of every registered output equals oe_i.
- R6: While rst_ni is low, all registers are cleared, so every registered output drives 1.
- R7: With cfg_pd_en_i=0, input PD_IDX is an ordinary literal, and a high level on it freezes nothing.
- R8: With cfg_pd_en_i=1, input PD_IDX reads as 0 in the array. From the first clock edge that samples it high, dout_o and den_o hold the values they had just before that edge, and registers do not load.
- R9: While frozen, changes on the inputs and on oe_i, and clock edges, do not change dout_o or den_o. A pin that was in high impedance stays in high impedance.
- R10: At the first edge that samples the power-down pin low, registers load from the state held through the freeze, and the outputs return to live evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up reset) |
| in_i | input | N_IN | Logic inputs; bit PD_IDX is dual-use |
| oe_i | input | 1 | Output enable for registered outputs |
| cfg_pt_i | input | N_OUT*N_PT*NLIT | Product-term literal masks |
| cfg_oe_i | input | N_OUT*NLIT | Enable-term literal masks for combinational outputs |
| cfg_reg_i | input | N_OUT | Per-output register select |
| cfg_pd_en_i | input | 1 | Makes input PD_IDX the power-down control |
| dout_o | output | N_OUT | Pin data |
| den_o | output | N_OUT | Pin driver enable (0 = high impedance) |

## Verification
A wrong feedback register appears one cycle after the faulty edge. It shows directly on a registered pin, and it shows on any combinational pin whose terms use that feedback literal. A freeze that leaks lets a pin move during power-down within the same cycle as the input or oe_i change. A register that loads during the freeze only becomes visible at the first edge after release, when the next state is computed from the wrong held value. A stale hold register shows as soon as the freeze takes effect.

// File: rtl/sop_pld_pkg.sv
package sop_pld_pkg;
  typedef struct packed {
    logic d;
    logic e;
  } pin_t;

  // literal index of a signal; inv selects the complement form
  function automatic int unsigned lit_pos(int unsigned sig, bit inv);
    return 2 * sig + (inv ? 1 : 0);
  endfunction
endpackage

// File: rtl/sop_lit_gen.sv
module sop_lit_gen #(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned N_FB   = 8,
  parameter int unsigned PD_IDX = 2
) (
  input  logic [N_IN-1:0]           in_i,
  input  logic [N_FB-1:0]           fb_i,
  input  logic                      pd_en_i,
  output logic [2*(N_IN+N_FB)-1:0]  lit_o
);
  logic [N_IN-1:0] in_eff;

  // control pin is withdrawn from the array when used for power-down
  always_comb begin
    in_eff = in_i;
    if (pd_en_i) in_eff[PD_IDX] = 1'b0;
  end

  for (genvar j = 0; j < N_IN; j++) begin : g_in
    assign lit_o[sop_pld_pkg::lit_pos(j, 1'b0)] = in_eff[j];
    assign lit_o[sop_pld_pkg::lit_pos(j, 1'b1)] = ~in_eff[j];
  end

  for (genvar k = 0; k < N_FB; k++) begin : g_fb
    assign lit_o[sop_pld_pkg::lit_pos(N_IN + k, 1'b0)] = fb_i[k];
    assign lit_o[sop_pld_pkg::lit_pos(N_IN + k, 1'b1)] = ~fb_i[k];
  end
endmodule

// File: rtl/sop_pterm_sum.sv
module sop_pterm_sum #(
  parameter int unsigned NLIT = 32,
  parameter int unsigned N_PT = 8
) (
  input  logic [N_PT*NLIT-1:0] mask_i,
  input  logic [NLIT-1:0]      oe_mask_i,
  input  logic [NLIT-1:0]      lit_i,
  output logic                 sum_o,
  output logic                 oe_o
);
  logic [N_PT-1:0] pt;

  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    logic [NLIT-1:0] m;
    assign m     = mask_i[t*NLIT +: NLIT];
    // empty term is off
    assign pt[t] = (|m) & (&(lit_i | ~m));
  end

  assign sum_o = |pt;
  // empty enable term is on
  assign oe_o  = &(lit_i | ~oe_mask_i);
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_pld_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic sum_i,
  input  logic reg_mode_i,
  input  logic oe_pin_i,
  input  logic oe_pt_i,
  output logic q_o,
  output pin_t pin_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (upd_i) q_o <= sum_i;
  end

  always_comb begin
    pin_o.d = reg_mode_i ? ~q_o : ~sum_i;
    pin_o.e = reg_mode_i ? oe_pin_i : oe_pt_i;
  end
endmodule

// File: rtl/sop_pld_core.sv
module sop_pld_core
  import sop_pld_pkg::*;
#(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned N_PT   = 8,
  parameter int unsigned PD_IDX = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [N_IN-1:0]                     in_i,
  input  logic                                oe_i,
  input  logic [N_OUT*N_PT*2*(N_IN+N_OUT)-1:0] cfg_pt_i,
  input  logic [N_OUT*2*(N_IN+N_OUT)-1:0]      cfg_oe_i,
  input  logic [N_OUT-1:0]                    cfg_reg_i,
  input  logic                                cfg_pd_en_i,
  output logic [N_OUT-1:0]                    dout_o,
  output logic [N_OUT-1:0]                    den_o
);
  localparam int unsigned NLIT = 2 * (N_IN + N_OUT);
  localparam int unsigned PT_W = N_PT * NLIT;

  logic [NLIT-1:0]  lit;
  logic [N_OUT-1:0] fb, sum, oe_pt;
  pin_t [N_OUT-1:0] live, hold;
  logic             pd_act, pd_q;

  assign pd_act = cfg_pd_en_i & in_i[PD_IDX];

  sop_lit_gen #(.N_IN(N_IN), .N_FB(N_OUT), .PD_IDX(PD_IDX)) u_lit (
    .in_i    (in_i),
    .fb_i    (fb),
    .pd_en_i (cfg_pd_en_i),
    .lit_o   (lit)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    sop_pterm_sum #(.NLIT(NLIT), .N_PT(N_PT)) u_pt (
      .mask_i    (cfg_pt_i[o*PT_W +: PT_W]),
      .oe_mask_i (cfg_oe_i[o*NLIT +: NLIT]),
      .lit_i     (lit),
      .sum_o     (sum[o]),
      .oe_o      (oe_pt[o])
    );

    sop_macrocell u_mc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .upd_i      (~pd_act),
      .sum_i      (sum[o]),
      .reg_mode_i (cfg_reg_i[o]),
      .oe_pin_i   (oe_i),
      .oe_pt_i    (oe_pt[o]),
      .q_o        (fb[o]),
      .pin_o      (live[o])
    );

    assign dout_o[o] = pd_q ? hold[o].d : live[o].d;
    assign den_o[o]  = pd_q ? hold[o].e : live[o].e;
  end

  // hold captures live pins up to the edge that enters power-down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q <= 1'b0;
      hold <= {N_OUT{2'b10}};
    end else begin
      pd_q <= pd_act;
      if (!pd_q) hold <= live;
    end
  end
endmodule

// File: rtl/sop_pld_core_chk.sv
module sop_pld_core_chk #(
  parameter int unsigned N_OUT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pd_en_i,
  input logic             pd_pin_i,
  input logic             oe_i,
  input logic [N_OUT-1:0] reg_mode_i,
  input logic [N_OUT-1:0] dout_i,
  input logic [N_OUT-1:0] den_i
);
  logic pd_act;
  assign pd_act = pd_en_i & pd_pin_i;

  // R6
  always_ff @(posedge clk_i) begin
    if (!rst_ni) reset_high_chk : assert (&(dout_i | ~reg_mode_i));
  end

  // R2
  out_known_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({dout_i, den_i}));

  // R5
  reg_oe_follow_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pd_act) |-> (((den_i ^ {N_OUT{oe_i}}) & reg_mode_i) == '0));

  // R8
  freeze_data_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(rst_ni, 2) && $past(pd_act) && $past(pd_act, 2)
    |-> $stable(dout_i));

  // R9
  hiz_keep_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(rst_ni, 2) && $past(pd_act) && $past(pd_act, 2)
    |-> $stable(den_i));
endmodule

bind sop_pld_core sop_pld_core_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pd_en_i    (cfg_pd_en_i),
  .pd_pin_i   (in_i[PD_IDX]),
  .oe_i       (oe_i),
  .reg_mode_i (cfg_reg_i),
  .dout_i     (dout_o),
  .den_i      (den_o)
);

// File: tb/sop_pld_core_tb.sv
`timescale 1ns/1ps
module sop_pld_core_tb_top;
  localparam int NI = 8, NO = 8, NP = 8, PDX = 2;
  localparam int NL = 2 * (NI + NO);

  logic                clk = 1'b0;
  logic                rst_n = 1'b1;
  logic [NI-1:0]       in = '0;
  logic                oe = 1'b1;
  logic [NO*NP*NL-1:0] cfg_pt = '0;
  logic [NO*NL-1:0]    cfg_oe = '0;
  logic [NO-1:0]       cfg_reg = '1;
  logic                pd_en = 1'b0;
  logic [NO-1:0]       dout, den;

  logic [NO-1:0] m_q = '0, m_hd = '1, m_he = '0;
  logic          m_pdq = 1'b0;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sop_pld_core #(.N_IN(NI), .N_OUT(NO), .N_PT(NP), .PD_IDX(PDX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in), .oe_i(oe),
    .cfg_pt_i(cfg_pt), .cfg_oe_i(cfg_oe), .cfg_reg_i(cfg_reg),
    .cfg_pd_en_i(pd_en), .dout_o(dout), .den_o(den)
  );

  function automatic logic [NL-1:0] f_lits();
    logic [NL-1:0] l;
    for (int j = 0; j < NI; j++) begin
      logic s;
      s = (pd_en && j == PDX) ? 1'b0 : in[j];
      l[2*j] = s; l[2*j+1] = ~s;
    end
    for (int k = 0; k < NO; k++) begin
      l[2*(NI+k)] = m_q[k]; l[2*(NI+k)+1] = ~m_q[k];
    end
    return l;
  endfunction

  function automatic logic f_sum(int o, logic [NL-1:0] l);
    logic s = 1'b0;
    for (int t = 0; t < NP; t++) begin
      logic [NL-1:0] m;
      m = cfg_pt[(o*NP+t)*NL +: NL];
      if (m != '0 && (l & m) == m) s = 1'b1;
    end
    return s;
  endfunction

  task automatic calc_live(output logic [NO-1:0] d, output logic [NO-1:0] e);
    logic [NL-1:0] l, m;
    l = f_lits();
    for (int o = 0; o < NO; o++) begin
      m = cfg_oe[o*NL +: NL];
      d[o] = cfg_reg[o] ? ~m_q[o] : ~f_sum(o, l);
      e[o] = cfg_reg[o] ? oe : ((l & m) == m);
    end
  endtask

  task automatic check(input string td, input string te);
    logic [NO-1:0] ed, ee;
    calc_live(ed, ee);
    if (m_pdq) begin ed = m_hd; ee = m_he; end
    total++;
    if (dout !== ed) begin
      bad++;
      $display("FAIL %s dout act=%h exp=%h", td, dout, ed);
    end
    total++;
    if (den !== ee) begin
      bad++;
      $display("FAIL %s den act=%h exp=%h", te, den, ee);
    end
  endtask

  task automatic edge_upd();
    logic [NO-1:0] ld, le, nq;
    logic pa;
    @(posedge clk);
    if (!rst_n) begin
      m_q = '0; m_pdq = 1'b0; m_hd = '1; m_he = '0;
    end else begin
      calc_live(ld, le);
      pa = pd_en & in[PDX];
      nq = m_q;
      if (!pa) for (int o = 0; o < NO; o++) nq[o] = f_sum(o, f_lits());
      if (!m_pdq) begin m_hd = ld; m_he = le; end
      m_pdq = pa;
      m_q = nq;
    end
    #1;
  endtask

  task automatic cyc(input logic [NI-1:0] ni, input logic noe, input string td, input string te);
    @(negedge clk);
    in = ni; oe = noe;
    #1 check(td, te);
    edge_upd();
  endtask

  task automatic rand_cfg(input logic [NO-1:0] regm);
    cfg_pt = '0; cfg_oe = '0; cfg_reg = regm;
    for (int o = 0; o < NO; o++) begin
      for (int t = 0; t < NP; t++) begin
        if ($urandom % 3 == 0) begin
          int n;
          n = 1 + $urandom % 3;
          for (int k = 0; k < n; k++) cfg_pt[(o*NP+t)*NL + $urandom % NL] = 1'b1;
        end
      end
      if ($urandom % 2 == 1) cfg_oe[o*NL + $urandom % NL] = 1'b1;
    end
  endtask

  function automatic logic [NI-1:0] rin(input bit force_pd, input bit pd_val);
    logic [NI-1:0] v;
    v = NI'($urandom);
    if (force_pd) v[PDX] = pd_val;
    return v;
  endfunction

  initial begin
    int seed_v;
    seed_v = $urandom(32'd4711);
    rand_cfg('1);
    #1 rst_n = 1'b0;
    // R6: registered outputs high under reset
    repeat (3) cyc(rin(0, 0), 1'b1, "R6", "R6");
    rst_n = 1'b1;

    // R1: directed literal encoding and empty terms
    cfg_pt = '0; cfg_oe = '0; cfg_reg = '0;
    cfg_pt[0*NL + 0] = 1'b1;               // in0 true
    cfg_pt[0*NL + 3] = 1'b1;               // in1 complement
    cfg_pt[(1*NP+3)*NL + 10] = 1'b1;       // in5 true and complement: never on
    cfg_pt[(1*NP+3)*NL + 11] = 1'b1;
    cyc(8'b0000_0001, 1'b1, "R1", "R4");
    cyc(8'b0000_0011, 1'b1, "R1", "R4");
    cyc(8'b0010_0001, 1'b0, "R1", "R4");
    cyc(8'b0000_0000, 1'b0, "R1", "R4");
    // R4: enable term on in0 complement for output 2
    cfg_oe[2*NL + 1] = 1'b1;
    cyc(8'b0000_0001, 1'b1, "R2", "R4");
    cyc(8'b0000_0000, 1'b1, "R2", "R4");

    // R3/R5: all registered, feedback in play
    for (int c = 0; c < 4; c++) begin
      rand_cfg('1);
      repeat (30) cyc(rin(0, 0), 1'($urandom), "R3", "R5");
    end
    // R2/R4: mixed modes
    for (int c = 0; c < 4; c++) begin
      rand_cfg(NO'($urandom));
      repeat (30) cyc(rin(0, 0), 1'($urandom), "R2", "R4");
    end
    // R7: pin high with power-down option off
    pd_en = 1'b0;
    for (int c = 0; c < 3; c++) begin
      rand_cfg(NO'($urandom));
      cfg_pt[(0*NP+0)*NL + 2*PDX] = 1'b1;
      repeat (15) cyc(rin(1, 1), 1'($urandom), "R7", "R7");
    end

    // R8/R9/R10: power-down episodes
    pd_en = 1'b1;
    for (int ep = 0; ep < 25; ep++) begin
      rand_cfg(NO'($urandom));
      cfg_pt[(1*NP+0)*NL + 2*PDX + 1] = 1'b1;  // pin complement literal (reads 0)
      repeat (3) cyc(rin(1, 0), 1'($urandom), "R8", "R8");
      cyc(rin(1, 1), 1'($urandom), "R8", "R8");
      repeat (4) cyc(rin(1, 1), 1'($urandom), "R9", "R9");
      repeat (3) cyc(rin(1, 0), 1'($urandom), "R10", "R10");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule